// File: doc/BRIEF.md
# Three-Loop Cycle-Granular Timing Aligner

This block keeps a fixed, selectable number of clock cycles between the active edge of a shared reference strobe and the active edge of a feedback signal that comes back from an external display path. Three independent colour loops share the reference. Each loop measures, in whole clock cycles, the interval from the reference edge to its own feedback edge, compares it with a target, and moves a delay tap count one step towards the target. The external path's delay can drift, and the tap count changes to absorb that drift.

Each loop delays six timing signals by its tap count: the strobe itself, a shift clock and four enables. The six signals pass through matched shift-register taps, so their relative phase is kept at the outputs. Two mode pins choose the pair of edge polarities that are compared and one of four target intervals. All inputs are plain level signals sampled on the rising clock edge. There is no stream interface and no back-pressure; every output is valid on every cycle.

Top module: `dll_timing_aligner`

## Requirements
- R1: With `edge_sel`=1 a falling edge of `ref_in` starts a measurement and a rising edge of that loop's `fb_in` ends it. With `edge_sel`=0 a rising reference edge starts it and a falling feedback edge ends it. The interval is the number of rising clock edges from the one that sees the start edge to the one that sees the end edge.
- R2: The target interval is 9 cycles for (`edge_sel`,`slow`)=(1,1), 15 for (1,0), 26 for (0,1) and 32 for (0,0).
- R3: On each completed measurement the tap count of that loop drops by one if the interval exceeds the target, rises by one if it falls short, and holds if it matches. It changes at no other time.
- R4: A tap count never goes below 0 or above `TAP_MAX` (default 26). A step that would pass either limit leaves it at the limit.
- R5: A measurement with no feedback end edge by the clock edge where its count reaches `TIMEOUT` (default 64) is dropped, and the tap count and lock flag stay as they were. A new reference start edge restarts any measurement still running.
- R6: `locked[i]` rises once 4 consecutive completed measurements of loop i have matched the target. It drops on the first completed measurement that does not match.
- R7: Output `sig_out[i*6+c]` equals channel input c (0 = `ref_in`, 1 = `sclk_in`, 2..5 = `en_in[0..3]`) delayed by exactly `tap_out[i]` clock cycles. A tap count of 0 passes the input through with no register.
- R8: The loops share `ref_in` and the mode pins but have their own feedback, tap count and lock flag. Different external delays settle at different tap counts.
- R9: While `rst` is high at a clock edge, every tap count loads `TAP_INIT` (default 8), every lock flag clears and every delay register clears to zero.
- R10: In the closed loop with an 11-cycle external delay and the 15-cycle setting, the tap count settles at 4 and the lock flag asserts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| edge_sel | input | 1 | Edge polarity select (R1) |
| slow | input | 1 | Target interval select (R2) |
| ref_in | input | 1 | Shared reference strobe, also channel 0 of every loop |
| sclk_in | input | 1 | Shift clock, channel 1 |
| en_in | input | NEN (4) | Enables, channels 2 to 5 |
| fb_in | input | NLOOP (3) | Feedback input per loop |
| sig_out | output | NLOOP*6 (18) | Delayed channels, loop i in bits [i*6 +: 6] |
| tap_out | output | NLOOP*TW (15) | Tap count per loop, loop i in bits [i*TW +: TW], TW=5 |
| locked | output | NLOOP (3) | Lock flag per loop |

## Verification
A wrong tap count is visible at the ports on the clock edge where it changes. `tap_out` moves, and all six delayed outputs of that loop take the input history from a different depth. The bench's behavioural model catches the mismatch in the next sampling slot. A wrong interval count or target does not change the outputs until the next reference edge has been followed by its feedback edge, which is up to about one reference period. After that the loop settles at a tap count other than target minus external delay, and the lock flag then differs from the model. A timeout bug shows only when feedback stays quiet, as a tap or lock change in a cycle where the model expects none.

// File: rtl/dll_pkg.sv
package dll_pkg;
  // Lock target in clock cycles, chosen by the edge polarity and the speed bit.
  function automatic logic [5:0] target_cycles(input logic edge_sel, input logic slow);
    case ({edge_sel, slow})
      2'b11:   return 6'd9;
      2'b10:   return 6'd15;
      2'b01:   return 6'd26;
      default: return 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/dll_edge_meas.sv
module dll_edge_meas #(
  parameter int TIMEOUT = 64,
  parameter int MW      = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          edge_sel,
  input  logic          start,
  input  logic          fb_in,
  output logic          done,
  output logic [MW-1:0] meas
);
  logic          fb_q, run;
  logic [MW-1:0] cnt;
  logic          fb_end;

  assign fb_end = edge_sel ? (~fb_q & fb_in) : (fb_q & ~fb_in);
  assign done   = run & ~start & fb_end;
  assign meas   = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_q <= 1'b0;
      run  <= 1'b0;
      cnt  <= '0;
    end else begin
      fb_q <= fb_in;
      if (start) begin
        run <= 1'b1;
        cnt <= MW'(1);
      end else if (run) begin
        if (fb_end || cnt == MW'(TIMEOUT)) run <= 1'b0;
        else cnt <= cnt + MW'(1);
      end
    end
  end

  AST_MEAS_BOUND: assert property (@(posedge clk) disable iff (rst)
    done |-> (meas >= MW'(1) && meas <= MW'(TIMEOUT))); // R5
  AST_TIMEOUT_STOP: assert property (@(posedge clk) disable iff (rst)
    (run && !start && !fb_end && cnt == MW'(TIMEOUT)) |=> !run); // R5
endmodule

// File: rtl/dll_tap_ctrl.sv
module dll_tap_ctrl #(
  parameter int TAP_MAX  = 26,
  parameter int TAP_INIT = 8,
  parameter int LOCK_N   = 4,
  parameter int TW       = 5,
  parameter int MW       = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          done,
  input  logic [MW-1:0] meas,
  input  logic [MW-1:0] target,
  output logic [TW-1:0] tap,
  output logic          locked
);
  localparam int LW = $clog2(LOCK_N + 1);
  logic [LW-1:0] match;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap    <= TW'(TAP_INIT);
      match  <= '0;
      locked <= 1'b0;
    end else if (done) begin
      if (meas == target) begin
        if (match < LW'(LOCK_N)) match <= match + LW'(1);
        locked <= (match + LW'(1) >= LW'(LOCK_N));
      end else begin
        match  <= '0;
        locked <= 1'b0;
        if (meas > target) begin
          if (tap != '0) tap <= tap - TW'(1);
        end else begin
          if (tap != TW'(TAP_MAX)) tap <= tap + TW'(1);
        end
      end
    end
  end

  AST_TAP_RANGE: assert property (@(posedge clk) disable iff (rst)
    tap <= TW'(TAP_MAX)); // R4
  AST_TAP_STEP: assert property (@(posedge clk) disable iff (rst)
    done |=> (tap == $past(tap) || tap == $past(tap) + TW'(1) || tap + TW'(1) == $past(tap))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(tap) && $stable(locked))); // R5
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
    (done && meas != target) |=> !locked); // R6
endmodule

// File: rtl/dll_tap_line.sv
module dll_tap_line #(
  parameter int NCH   = 6,
  parameter int DEPTH = 26,
  parameter int TW    = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [TW-1:0]  tap,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] dout
);
  logic [NCH-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) sr[0] <= '0;
    else     sr[0] <= din;
  end

  for (genvar k = 1; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) sr[k] <= '0;
      else     sr[k] <= sr[k-1];
    end
  end

  always_comb begin
    dout = din;
    for (int k = 1; k <= DEPTH; k++)
      if (tap == TW'(k)) dout = sr[k-1];
  end

  AST_LINE_SHIFT: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (sr[0] == $past(din) || $past(rst))); // R7
endmodule

// File: rtl/dll_timing_aligner.sv
module dll_timing_aligner #(
  parameter int NLOOP    = 3,
  parameter int NEN      = 4,
  parameter int TAP_MAX  = 26,
  parameter int TAP_INIT = 8,
  parameter int TIMEOUT  = 64,
  parameter int LOCK_N   = 4,
  localparam int NCH     = 2 + NEN,
  localparam int TW      = $clog2(TAP_MAX + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   edge_sel,
  input  logic                   slow,
  input  logic                   ref_in,
  input  logic                   sclk_in,
  input  logic [NEN-1:0]         en_in,
  input  logic [NLOOP-1:0]       fb_in,
  output logic [NLOOP*NCH-1:0]   sig_out,
  output logic [NLOOP*TW-1:0]    tap_out,
  output logic [NLOOP-1:0]       locked
);
  localparam int MW = $clog2(TIMEOUT + 1);

  logic           ref_q, ref_start;
  logic [MW-1:0]  target;
  logic [NCH-1:0] chan;

  always_ff @(posedge clk) begin
    if (rst) ref_q <= 1'b0;
    else     ref_q <= ref_in;
  end

  assign ref_start = edge_sel ? (ref_q & ~ref_in) : (~ref_q & ref_in);
  assign target    = MW'(dll_pkg::target_cycles(edge_sel, slow));
  assign chan      = {en_in, sclk_in, ref_in};

  for (genvar i = 0; i < NLOOP; i++) begin : g_loop
    logic          done;
    logic [MW-1:0] meas;
    logic [TW-1:0] tap;

    dll_edge_meas #(.TIMEOUT(TIMEOUT), .MW(MW)) i_meas (
      .clk(clk), .rst(rst), .edge_sel(edge_sel), .start(ref_start),
      .fb_in(fb_in[i]), .done(done), .meas(meas));

    dll_tap_ctrl #(.TAP_MAX(TAP_MAX), .TAP_INIT(TAP_INIT), .LOCK_N(LOCK_N),
                   .TW(TW), .MW(MW)) i_ctrl (
      .clk(clk), .rst(rst), .done(done), .meas(meas), .target(target),
      .tap(tap), .locked(locked[i]));

    dll_tap_line #(.NCH(NCH), .DEPTH(TAP_MAX), .TW(TW)) i_line (
      .clk(clk), .rst(rst), .tap(tap), .din(chan),
      .dout(sig_out[i*NCH +: NCH]));

    assign tap_out[i*TW +: TW] = tap;
  end

  AST_RESET_TAP: assert property (@(posedge clk)
    rst |=> (tap_out[TW-1:0] == TW'(TAP_INIT) && locked == '0)); // R9
endmodule

// File: tb/test_dll_timing_aligner.sv
`timescale 1ns/1ps
module test_dll_timing_aligner;
  localparam int NL = 3, NCH = 6, TMAX = 26, TINIT = 8, TOUT = 64, TW = 5;
  localparam int PER = 100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic edge_sel = 1'b1, slow = 1'b0, ref_in = 1'b0, sclk_in = 1'b0;
  logic [3:0] en_in = '0;
  logic [NL-1:0] fb_in = '1;
  logic [NL*NCH-1:0] sig_out;
  logic [NL*TW-1:0] tap_out;
  logic [NL-1:0] locked;

  always #2.5 clk = ~clk;

  dll_timing_aligner i_dll_timing_aligner (
    .clk(clk), .rst(rst), .edge_sel(edge_sel), .slow(slow), .ref_in(ref_in),
    .sclk_in(sclk_in), .en_in(en_in), .fb_in(fb_in), .sig_out(sig_out),
    .tap_out(tap_out), .locked(locked));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference state
  int m_tap[NL], m_cnt[NL], m_match[NL];
  bit m_run[NL], m_lock[NL], m_fq[NL], m_rq;
  bit [5:0] hist[$];
  // external path model
  int ext[NL];
  bit freeze[NL];
  bit sh[NL][0:63];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int tgt();
    if (edge_sel && slow) return 9;
    if (edge_sel) return 15;
    if (slow) return 26;
    return 32;
  endfunction

  task automatic model_edge();
    if (rst) begin
      for (int l = 0; l < NL; l++) begin
        m_tap[l] = TINIT; m_cnt[l] = 0; m_match[l] = 0;
        m_run[l] = 0; m_lock[l] = 0; m_fq[l] = 0;
      end
      m_rq = 0;
      hist.delete();
      for (int k = 0; k < TMAX; k++) hist.push_back(6'd0);
    end else begin
      bit rs;
      rs = edge_sel ? (m_rq && !ref_in) : (!m_rq && ref_in);
      for (int l = 0; l < NL; l++) begin
        bit fe;
        fe = edge_sel ? (!m_fq[l] && fb_in[l]) : (m_fq[l] && !fb_in[l]);
        if (rs) begin
          m_run[l] = 1; m_cnt[l] = 1;
        end else if (m_run[l]) begin
          if (fe) begin
            m_run[l] = 0;
            if (m_cnt[l] == tgt()) begin
              if (m_match[l] < 4) m_match[l]++;
              m_lock[l] = (m_match[l] >= 4);
            end else begin
              m_match[l] = 0; m_lock[l] = 0;
              if (m_cnt[l] > tgt()) begin if (m_tap[l] > 0) m_tap[l]--; end
              else begin if (m_tap[l] < TMAX) m_tap[l]++; end
            end
          end else if (m_cnt[l] == TOUT) m_run[l] = 0;
          else m_cnt[l]++;
        end
        m_fq[l] = fb_in[l];
      end
      m_rq = ref_in;
      hist.push_front({en_in, sclk_in, ref_in});
      void'(hist.pop_back());
    end
  endtask

  task automatic compare();
    bit [5:0] cur, ev, av;
    cur = {en_in, sclk_in, ref_in};
    for (int l = 0; l < NL; l++) begin
      ev = (m_tap[l] == 0) ? cur : hist[m_tap[l]-1];
      av = sig_out[l*NCH +: NCH];
      chk(int'(tap_out[l*TW +: TW]) == m_tap[l], "R3 tap", int'(tap_out[l*TW +: TW]), m_tap[l]);
      chk(locked[l] == m_lock[l], "R6 lock", int'(locked[l]), int'(m_lock[l]));
      chk(av == ev, "R7 channels", int'(av), int'(ev));
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
    cyc++;
    ref_in  = (cyc % PER) < (PER / 2);
    sclk_in = cyc[1];
    en_in   = cyc[6:3] ^ {3'b0, cyc[9]};
    #1;
    for (int l = 0; l < NL; l++) begin
      for (int k = 63; k > 0; k--) sh[l][k] = sh[l][k-1];
      sh[l][0] = sig_out[l*NCH];
      if (!freeze[l]) fb_in[l] = ~sh[l][ext[l]];
    end
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  function automatic int tap_of(input int l);
    return int'(tap_out[l*TW +: TW]);
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int l = 0; l < NL; l++) begin
      freeze[l] = 0;
      for (int k = 0; k < 64; k++) sh[l][k] = 0;
    end
    ext[0] = 11; ext[1] = 5; ext[2] = 9;
    edge_sel = 1; slow = 0;
    run(4);
    rst = 0;
    // R9: reset state
    for (int l = 0; l < NL; l++) begin
      chk(tap_of(l) == TINIT, "R9 tap after reset", tap_of(l), TINIT);
      chk(locked[l] == 0, "R9 lock after reset", int'(locked[l]), 0);
    end
    chk(sig_out == '0, "R9 delay lines cleared", int'(sig_out), 0);

    // S1: edge_sel=1 slow=0, target 15 (R1, R2, R10, R8)
    run(30 * PER);
    chk(tap_of(0) == 4, "R10 tap with 11-cycle path", tap_of(0), 4);
    chk(locked[0] == 1, "R10 locked", int'(locked[0]), 1);
    chk(tap_of(1) == 10, "R8 loop1 independent tap", tap_of(1), 10);
    chk(tap_of(2) == 6, "R8 loop2 independent tap", tap_of(2), 6);

    // S2: target 9; loop1 to low limit, loop2 feedback silent
    slow = 1; ext[0] = 3; ext[1] = 12; freeze[2] = 1;
    run(2);
    run(25 * PER);
    chk(tap_of(0) == 6, "R2 target 9 tap", tap_of(0), 6);
    chk(locked[0] == 1, "R6 relock after path change", int'(locked[0]), 1);
    chk(tap_of(1) == 0, "R4 low saturation", tap_of(1), 0);
    chk(locked[1] == 0, "R6 no lock at limit", int'(locked[1]), 0);
    chk(tap_of(2) == 6, "R5 timeout keeps tap", tap_of(2), 6);

    // S3: edge_sel=0 slow=1, target 26, opposite polarities (R1)
    edge_sel = 0; ext[0] = 2; ext[1] = 1; ext[2] = 3; freeze[2] = 0;
    run(36 * PER);
    chk(tap_of(0) == 24, "R1 falling-edge feedback tap", tap_of(0), 24);
    chk(tap_of(1) == 25, "R2 target 26 tap", tap_of(1), 25);
    chk(tap_of(2) == 23, "R8 loop2 tap", tap_of(2), 23);
    chk(locked == 3'b111, "R6 all locked", int'(locked), 7);

    // S4: target 32, taps run into the upper limit
    slow = 0; ext[2] = 6;
    run(15 * PER);
    chk(tap_of(0) == TMAX, "R4 high saturation loop0", tap_of(0), TMAX);
    chk(tap_of(1) == TMAX, "R4 high saturation loop1", tap_of(1), TMAX);
    chk(locked[1:0] == 2'b00, "R6 unlocked at limit", int'(locked[1:0]), 0);
    chk(tap_of(2) == TMAX && locked[2], "R2 target 32 exact", tap_of(2), TMAX);

    // R9: reset again with filled delay lines
    rst = 1;
    run(2);
    rst = 0;
    chk(tap_out == {3{5'(TINIT)}}, "R9 tap reload", int'(tap_out), TINIT);
    chk(locked == '0, "R9 lock clear", int'(locked), 0);
    run(20);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule